// File: doc/BRIEF.md
# Boundary-Scan Pad Data Register

This block is the serial test register that sits between a device's core logic and its pads. It holds one scan cell for each observable or controllable pad signal, plus three cells for internal test use. Externally generated test-access strobes control it. A capture strobe loads every cell in parallel from its source. A shift strobe moves the whole chain one position toward the serial output. An update strobe copies the chain into holding registers, which drive the pads whenever the external-test mode is on. A one-bit bypass path can replace the whole chain between the serial input and the serial output.

Pins come in three kinds, and each kind is a parameter. A bidirectional pin adds three cells: pad input, then output value, then output enable. An input-only pin adds one cell. An output-only pin adds the full set of three. Two observation cells come first in the chain, for an internal enable and an internal value. One control cell comes last, and its held value drives an internal net. A small decode picks the chain operation on every clock edge, using three named states: `OP_IDLE` (hold), `OP_CAPTURE` (parallel load) and `OP_SHIFT` (serial move). The transitions are set by the strobes alone: no enable or bypass selected goes to `OP_IDLE`, enable with shift deasserted goes to `OP_CAPTURE`, and enable with shift asserted goes to `OP_SHIFT`. The test-access state machine and instruction decoding sit outside this block.

Top module: `bscan_io_chain`

## Requirements
- R1: The chain holds 3 + 3·NB + NI + 3·NO cells, with index 0 nearest the serial output. Index 0 observes `int_t_obs` and index 1 observes `int_o_obs`. Bidirectional pin k occupies indices 2+3k (pad input), 3+3k (output value) and 4+3k (output enable). Input-only pin j occupies index 2+3·NB+j. Output-only pin m starts at index b = 2+3·NB+NI+3m and occupies b (driven pad value), b+1 (output value) and b+2 (output enable). The last index observes `int_net`.
- R2: On a rising clock edge with `dr_en`=1, `shift_sel`=0 and `bypass_sel`=0, every cell loads its source from R1. The output-only pad-value cell captures what is actually driven on `oo_pad_o`.
- R3: On a rising edge with `dr_en`=1, `shift_sel`=1 and `bypass_sel`=0, every cell takes the value of the cell above it, and the last cell takes `tdi`. After the chain length in shifts, bit k of the chain equals the `tdi` value of shift k.
- R4: With `dr_en`=0, the chain keeps its contents whatever `shift_sel`, `tdi` and the pads do.
- R5: `tdo` changes only on the falling clock edge. It then takes the bypass bit when `bypass_sel`=1, and chain index 0 otherwise.
- R6: On a rising edge with `upd_en`=1 and `bypass_sel`=0, the holding registers load the chain's output-value, output-enable and last cells. `int_net` follows the last cell in every mode.
- R7: With `extest`=1, each `*_pad_o` and `*_pad_t` bit comes from the holding register of its pin's output-value and output-enable cells.
- R8: With `extest`=0, the pad outputs equal the core's value and enable inputs. Holding registers and `int_net` keep their values on every edge without an update.
- R9: With `bypass_sel`=1, a capture loads 0 into the bypass bit and a shift loads `tdi` into it. Neither operation, nor an update strobe, changes the chain or `int_net`.
- R10: An active-low `rst_n` clears the chain, the bypass bit, the holding registers and `tdo` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock for the data register |
| rst_n | input | 1 | Asynchronous reset, active low |
| dr_en | input | 1 | Clock enable for capture or shift |
| shift_sel | input | 1 | 1 shifts, 0 captures |
| upd_en | input | 1 | Load the holding registers |
| extest | input | 1 | Drive the pads from the holding registers |
| bypass_sel | input | 1 | Route through the one-bit bypass |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling edge |
| bi_pad_in | input | NB | Bidirectional pad input values |
| bi_core_o | input | NB | Core output values, bidirectional pins |
| bi_core_t | input | NB | Core output enables, bidirectional pins |
| bi_pad_o | output | NB | Values driven to bidirectional pads |
| bi_pad_t | output | NB | Enables driven to bidirectional pads |
| in_pad_in | input | NI | Input-only pad values |
| oo_core_o | input | NO | Core output values, output-only pins |
| oo_core_t | input | NO | Core output enables, output-only pins |
| oo_pad_o | output | NO | Values driven to output-only pads |
| oo_pad_t | output | NO | Enables driven to output-only pads |
| int_t_obs | input | 1 | Internal enable to observe |
| int_o_obs | input | 1 | Internal value to observe |
| int_net | output | 1 | Internal net driven by the last cell |

## Verification
The bench builds the block with two bidirectional pins, one input-only pin and one output-only pin, which gives a 13-cell chain. That configuration contains every pin kind and both special ends. It is also short enough to read out every cell after every capture. Thirty-two capture patterns give each cell source both logic values. Sixteen shift-in patterns go through update, external-test drive and latch hold, and each one is read back serially. Separate sequences cover the falling-edge output timing, the bypass path with its untouched chain, the hold behaviour and a reset in mid-run.

// File: rtl/bscan_io_pkg.sv
package bscan_io_pkg;

    // Chain operation chosen on each rising clock edge.
    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_SHIFT   = 2'd2
    } scan_op_e;

    localparam int unsigned END_CELLS   = 3;  // two observers plus one control cell
    localparam int unsigned HEAD_CELLS  = 2;  // observers ahead of the pin groups
    localparam int unsigned GROUP_CELLS = 3;  // input, value, enable

    function automatic int unsigned chain_len(input int unsigned nb,
                                              input int unsigned ni,
                                              input int unsigned no);
        return END_CELLS + GROUP_CELLS * nb + ni + GROUP_CELLS * no;
    endfunction

    // First cell of driving pin p: bidirectional pins first, then output-only ones.
    function automatic int unsigned group_base(input int unsigned p,
                                               input int unsigned nb,
                                               input int unsigned ni);
        if (p < nb)
            return HEAD_CELLS + GROUP_CELLS * p;
        else
            return HEAD_CELLS + GROUP_CELLS * nb + ni + GROUP_CELLS * (p - nb);
    endfunction

endpackage

// File: rtl/bscan_shift_chain.sv
module bscan_shift_chain
    import bscan_io_pkg::*;
#(
    parameter int unsigned NB  = 2,
    parameter int unsigned NI  = 1,
    parameter int unsigned NO  = 1,
    parameter int unsigned LEN = chain_len(NB, NI, NO),
    parameter int unsigned NP  = NB + NO
) (
    input  logic           clk,
    input  logic           rst_n,
    input  scan_op_e       op,
    input  logic           tdi,
    input  logic [LEN-1:0] cap,
    output logic           chain_so,
    output logic [NP-1:0]  tap_o,
    output logic [NP-1:0]  tap_t,
    output logic           tap_net
);

    logic [LEN-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '0;
        end else begin
            unique case (op)
                OP_CAPTURE: sr <= cap;
                OP_SHIFT:   sr <= {tdi, sr[LEN-1:1]};
                OP_IDLE:    sr <= sr;
                default:    sr <= sr;
            endcase
        end
    end

    for (genvar p = 0; p < NP; p++) begin : g_tap
        localparam int unsigned B = group_base(p, NB, NI);
        assign tap_o[p] = sr[B+1];
        assign tap_t[p] = sr[B+2];
    end

    assign tap_net  = sr[LEN-1];
    assign chain_so = sr[0];

endmodule

// File: rtl/bscan_update_stage.sv
module bscan_update_stage #(
    parameter int unsigned NP = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          extest,
    input  logic [NP-1:0] tap_o,
    input  logic [NP-1:0] tap_t,
    input  logic          tap_net,
    input  logic [NP-1:0] core_o,
    input  logic [NP-1:0] core_t,
    output logic [NP-1:0] pad_o,
    output logic [NP-1:0] pad_t,
    output logic          net
);

    logic [NP-1:0] hold_o;
    logic [NP-1:0] hold_t;
    logic          hold_net;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_o   <= '0;
            hold_t   <= '0;
            hold_net <= 1'b0;
        end else if (load) begin
            hold_o   <= tap_o;
            hold_t   <= tap_t;
            hold_net <= tap_net;
        end
    end

    always_comb begin
        pad_o = extest ? hold_o : core_o;
        pad_t = extest ? hold_t : core_t;
        net   = hold_net;
    end

endmodule

// File: rtl/bscan_serial_out.sv
module bscan_serial_out (
    input  logic clk,
    input  logic rst_n,
    input  logic byp_en,
    input  logic shift_sel,
    input  logic bypass_sel,
    input  logic tdi,
    input  logic chain_so,
    output logic byp_q,
    output logic tdo
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            byp_q <= 1'b0;
        else if (byp_en)
            byp_q <= shift_sel ? tdi : 1'b0;
    end

    // Falling-edge launch keeps tdo settled around the next rising edge.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)
            tdo <= 1'b0;
        else
            tdo <= bypass_sel ? byp_q : chain_so;
    end

endmodule

// File: rtl/bscan_io_chain.sv
module bscan_io_chain
    import bscan_io_pkg::*;
#(
    parameter int unsigned NB = 8,
    parameter int unsigned NI = 2,
    parameter int unsigned NO = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dr_en,
    input  logic          shift_sel,
    input  logic          upd_en,
    input  logic          extest,
    input  logic          bypass_sel,
    input  logic          tdi,
    output logic          tdo,
    input  logic [NB-1:0] bi_pad_in,
    input  logic [NB-1:0] bi_core_o,
    input  logic [NB-1:0] bi_core_t,
    output logic [NB-1:0] bi_pad_o,
    output logic [NB-1:0] bi_pad_t,
    input  logic [NI-1:0] in_pad_in,
    input  logic [NO-1:0] oo_core_o,
    input  logic [NO-1:0] oo_core_t,
    output logic [NO-1:0] oo_pad_o,
    output logic [NO-1:0] oo_pad_t,
    input  logic          int_t_obs,
    input  logic          int_o_obs,
    output logic          int_net
);

    localparam int unsigned LEN = chain_len(NB, NI, NO);
    localparam int unsigned NP  = NB + NO;
    localparam int unsigned IN0 = HEAD_CELLS + GROUP_CELLS * NB;

    scan_op_e       op;
    logic [LEN-1:0] cap;
    logic           chain_so;
    logic [NP-1:0]  tap_o;
    logic [NP-1:0]  tap_t;
    logic           tap_net;
    logic [NP-1:0]  core_o_all;
    logic [NP-1:0]  core_t_all;
    logic [NP-1:0]  pad_o_all;
    logic [NP-1:0]  pad_t_all;
    logic           byp_q;
    logic           upd_load;
    logic           byp_en;

    // Operation decode: bypass steals the strobes from the chain.
    always_comb begin
        unique case ({dr_en & ~bypass_sel, shift_sel})
            2'b10:   op = OP_CAPTURE;
            2'b11:   op = OP_SHIFT;
            default: op = OP_IDLE;
        endcase
    end

    assign upd_load = upd_en & ~bypass_sel;
    assign byp_en   = dr_en & bypass_sel;

    // Parallel capture sources in chain order.
    assign cap[0]     = int_t_obs;
    assign cap[1]     = int_o_obs;
    assign cap[LEN-1] = int_net;

    for (genvar k = 0; k < NB; k++) begin : g_bidir
        localparam int unsigned B = group_base(k, NB, NI);
        assign cap[B]   = bi_pad_in[k];
        assign cap[B+1] = bi_core_o[k];
        assign cap[B+2] = bi_core_t[k];
    end

    for (genvar j = 0; j < NI; j++) begin : g_inonly
        assign cap[IN0+j] = in_pad_in[j];
    end

    for (genvar m = 0; m < NO; m++) begin : g_outonly
        localparam int unsigned B = group_base(NB + m, NB, NI);
        assign cap[B]   = oo_pad_o[m];
        assign cap[B+1] = oo_core_o[m];
        assign cap[B+2] = oo_core_t[m];
    end

    assign core_o_all = {oo_core_o, bi_core_o};
    assign core_t_all = {oo_core_t, bi_core_t};
    assign bi_pad_o   = pad_o_all[NB-1:0];
    assign bi_pad_t   = pad_t_all[NB-1:0];
    assign oo_pad_o   = pad_o_all[NP-1:NB];
    assign oo_pad_t   = pad_t_all[NP-1:NB];

    bscan_shift_chain #(.NB(NB), .NI(NI), .NO(NO)) i_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .tdi      (tdi),
        .cap      (cap),
        .chain_so (chain_so),
        .tap_o    (tap_o),
        .tap_t    (tap_t),
        .tap_net  (tap_net)
    );

    bscan_update_stage #(.NP(NP)) i_update (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (upd_load),
        .extest  (extest),
        .tap_o   (tap_o),
        .tap_t   (tap_t),
        .tap_net (tap_net),
        .core_o  (core_o_all),
        .core_t  (core_t_all),
        .pad_o   (pad_o_all),
        .pad_t   (pad_t_all),
        .net     (int_net)
    );

    bscan_serial_out i_serial (
        .clk        (clk),
        .rst_n      (rst_n),
        .byp_en     (byp_en),
        .shift_sel  (shift_sel),
        .bypass_sel (bypass_sel),
        .tdi        (tdi),
        .chain_so   (chain_so),
        .byp_q      (byp_q),
        .tdo        (tdo)
    );

endmodule

// File: rtl/bscan_io_chain_chk.sv
module bscan_io_chain_chk #(
    parameter int unsigned NB = 2,
    parameter int unsigned NO = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dr_en,
    input logic          shift_sel,
    input logic          upd_en,
    input logic          extest,
    input logic          bypass_sel,
    input logic          tdi,
    input logic          tdo,
    input logic [NB-1:0] bi_core_o,
    input logic [NB-1:0] bi_pad_o,
    input logic [NO-1:0] oo_core_o,
    input logic [NO-1:0] oo_pad_o,
    input logic          int_net,
    input logic          chain_so,
    input logic          byp_q,
    input logic          tap_net
);

    a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !dr_en |=> $stable(chain_so));

    a_r5_tdo_source: assert property (@(posedge clk) disable iff (!rst_n)
        tdo == ($past(bypass_sel) ? byp_q : chain_so));

    a_r6_net_load: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !bypass_sel) |=> int_net == $past(tap_net));

    a_r8_net_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_en && !bypass_sel) |=> $stable(int_net));

    a_r8_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        !extest |-> (bi_pad_o == bi_core_o) && (oo_pad_o == oo_core_o));

    a_r9_bypass_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_en && bypass_sel && !shift_sel) |=> byp_q == 1'b0);

    a_r9_bypass_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_en && bypass_sel && shift_sel) |=> byp_q == $past(tdi));

    a_r9_chain_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_en && bypass_sel) |=> $stable(chain_so));

endmodule

bind bscan_io_chain bscan_io_chain_chk #(.NB(NB), .NO(NO)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dr_en      (dr_en),
    .shift_sel  (shift_sel),
    .upd_en     (upd_en),
    .extest     (extest),
    .bypass_sel (bypass_sel),
    .tdi        (tdi),
    .tdo        (tdo),
    .bi_core_o  (bi_core_o),
    .bi_pad_o   (bi_pad_o),
    .oo_core_o  (oo_core_o),
    .oo_pad_o   (oo_pad_o),
    .int_net    (int_net),
    .chain_so   (chain_so),
    .byp_q      (byp_q),
    .tap_net    (tap_net)
);

// File: tb/test_bscan_io_chain.sv
module test_bscan_io_chain;

    localparam int NB = 2;
    localparam int NI = 1;
    localparam int NO = 1;
    localparam int L  = 3 + 3 * NB + NI + 3 * NO;  // 13 cells
    localparam int OB = 2 + 3 * NB + NI;           // output-only pin group start

    logic clk = 1'b0;
    logic rst_n, dr_en, shift_sel, upd_en, extest, bypass_sel, tdi;
    logic tdo;
    logic [NB-1:0] bi_pad_in, bi_core_o, bi_core_t, bi_pad_o, bi_pad_t;
    logic [NI-1:0] in_pad_in;
    logic [NO-1:0] oo_core_o, oo_core_t, oo_pad_o, oo_pad_t;
    logic int_t_obs, int_o_obs, int_net;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    logic [L-1:0] lat = '0;  // model of the last updated chain contents

    always #10 clk = ~clk;  // 50 MHz

    bscan_io_chain #(.NB(NB), .NI(NI), .NO(NO)) i_bscan_io_chain (
        .clk(clk), .rst_n(rst_n), .dr_en(dr_en), .shift_sel(shift_sel),
        .upd_en(upd_en), .extest(extest), .bypass_sel(bypass_sel),
        .tdi(tdi), .tdo(tdo),
        .bi_pad_in(bi_pad_in), .bi_core_o(bi_core_o), .bi_core_t(bi_core_t),
        .bi_pad_o(bi_pad_o), .bi_pad_t(bi_pad_t),
        .in_pad_in(in_pad_in),
        .oo_core_o(oo_core_o), .oo_core_t(oo_core_t),
        .oo_pad_o(oo_pad_o), .oo_pad_t(oo_pad_t),
        .int_t_obs(int_t_obs), .int_o_obs(int_o_obs), .int_net(int_net)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive at falling edge + 1, return at the next falling edge + 1.
    task automatic step(input logic den, input logic ssel, input logic upd, input logic din);
        dr_en = den; shift_sel = ssel; upd_en = upd; tdi = din;
        @(posedge clk);
        @(negedge clk);
        #1;
        dr_en = 1'b0; upd_en = 1'b0;
    endtask

    task automatic shift_in(input logic [L-1:0] v);
        for (int k = 0; k < L; k++) step(1'b1, 1'b1, 1'b0, v[k]);
    endtask

    task automatic read_out(input logic [L-1:0] exp, input string tag);
        check(tag, tdo, exp[0]);
        for (int k = 1; k < L; k++) begin
            step(1'b1, 1'b1, 1'b0, 1'b0);
            check(tag, tdo, exp[k]);
        end
    endtask

    function automatic logic [L-1:0] cap_model();
        logic [L-1:0] c;
        c[0] = int_t_obs;
        c[1] = int_o_obs;
        for (int k = 0; k < NB; k++) begin
            c[2+3*k] = bi_pad_in[k];
            c[3+3*k] = bi_core_o[k];
            c[4+3*k] = bi_core_t[k];
        end
        c[2+3*NB] = in_pad_in[0];
        c[OB]     = extest ? lat[OB+1] : oo_core_o[0];
        c[OB+1]   = oo_core_o[0];
        c[OB+2]   = oo_core_t[0];
        c[L-1]    = lat[L-1];
        return c;
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin : main
        logic [L-1:0] v, w, e;
        logic [31:0]  tmp;
        rst_n = 1'b0; dr_en = 0; shift_sel = 0; upd_en = 0; extest = 0;
        bypass_sel = 0; tdi = 0;
        bi_pad_in = 2'b01; bi_core_o = 2'b10; bi_core_t = 2'b01; in_pad_in = 1'b1;
        oo_core_o = 1'b1; oo_core_t = 1'b0; int_t_obs = 1'b1; int_o_obs = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        check("R10 reset tdo", tdo, 0);
        check("R10 reset int_net", int_net, 0);
        check("R8 reset passthru bi_pad_o", bi_pad_o, bi_core_o);
        check("R8 reset passthru oo_pad_t", oo_pad_t, oo_core_t);
        @(negedge clk);
        #1;
        rst_n = 1'b1;

        // R1 R2: capture sweep with serial readout of every cell
        for (int p = 0; p < 32; p++) begin
            bi_pad_in = p[1:0]; bi_core_o = p[3:2]; bi_core_t = {p[4], p[0]} ^ 2'b10;
            in_pad_in = p[2]; oo_core_o = p[4]; oo_core_t = p[1];
            int_t_obs = p[3]; int_o_obs = ~p[0];
            e = cap_model();
            step(1'b1, 1'b0, 1'b0, 1'b0);
            read_out(e, "R1 R2 capture layout");
        end

        // R3 R6 R7 R8: shift in, update, external-test drive, hold
        for (int p = 0; p < 16; p++) begin
            tmp = (p * 32'h9E37) ^ 32'h5A3C;
            v = tmp[L-1:0];
            w = ~v;
            bi_core_o = p[1:0]; bi_core_t = ~p[1:0]; oo_core_o = p[2]; oo_core_t = p[3];
            shift_in(v);
            step(1'b0, 1'b0, 1'b1, 1'b0);
            lat = v;
            check("R6 update int_net", int_net, v[L-1]);
            check("R8 passthru bi_pad_o", bi_pad_o, bi_core_o);
            check("R8 passthru bi_pad_t", bi_pad_t, bi_core_t);
            check("R8 passthru oo_pad_o", oo_pad_o, oo_core_o);
            extest = 1'b1;
            #1;
            for (int k = 0; k < NB; k++) begin
                check("R7 extest bi_pad_o", bi_pad_o[k], v[3+3*k]);
                check("R7 extest bi_pad_t", bi_pad_t[k], v[4+3*k]);
            end
            check("R7 extest oo_pad_o", oo_pad_o, v[OB+1]);
            check("R7 extest oo_pad_t", oo_pad_t, v[OB+2]);
            shift_in(w);
            check("R8 hold bi_pad_o", bi_pad_o, {v[6], v[3]});
            check("R8 hold oo_pad_t", oo_pad_t, v[OB+2]);
            check("R8 hold int_net", int_net, v[L-1]);
            read_out(w, "R3 shift order");
            e = cap_model();
            step(1'b1, 1'b0, 1'b0, 1'b0);
            read_out(e, "R2 capture under extest");
            extest = 1'b0;
        end

        // R5: tdo moves on the falling edge only
        v = '0; v[1] = 1'b1;
        shift_in(v);
        check("R5 tdo before shift", tdo, 0);
        dr_en = 1'b1; shift_sel = 1'b1; tdi = 1'b0;
        @(posedge clk);
        #1;
        check("R5 tdo held after rising edge", tdo, 0);
        @(negedge clk);
        #1;
        check("R5 tdo after falling edge", tdo, 1);
        dr_en = 1'b0;

        // R4: hold while dr_en is low
        v = 13'h0B6D;
        shift_in(v);
        for (int k = 0; k < 5; k++) begin
            bi_pad_in = k[1:0]; int_t_obs = ~int_t_obs;
            step(1'b0, k[0], 1'b0, ~k[0]);
            check("R4 hold tdo", tdo, v[0]);
        end
        read_out(v, "R4 hold contents");

        // R9: bypass path
        v = 13'h1C39;
        shift_in(v);
        bypass_sel = 1'b1;
        step(1'b1, 1'b1, 1'b0, 1'b1);
        check("R9 bypass shift one", tdo, 1);
        step(1'b1, 1'b0, 1'b0, 1'b1);
        check("R9 bypass capture zero", tdo, 0);
        tmp = 32'h000000B4;
        for (int k = 0; k < 8; k++) begin
            step(1'b1, 1'b1, 1'b0, tmp[k]);
            check("R9 bypass shift", tdo, tmp[k]);
        end
        step(1'b0, 1'b0, 1'b1, 1'b0);
        check("R9 update ignored in bypass", int_net, lat[L-1]);
        bypass_sel = 1'b0;
        step(1'b0, 1'b0, 1'b0, 1'b0);
        read_out(v, "R9 chain untouched by bypass");

        // R10: reset in mid-run
        shift_in(13'h1FFF);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        extest = 1'b1;
        #1;
        check("R10 preload int_net", int_net, 1);
        rst_n = 1'b0;
        #1;
        check("R10 async tdo", tdo, 0);
        check("R10 async int_net", int_net, 0);
        check("R10 async holding bi_pad_o", bi_pad_o, 0);
        check("R10 async holding oo_pad_t", oo_pad_t, 0);
        @(negedge clk);
        #1;
        rst_n = 1'b1;
        lat = '0;
        extest = 1'b0;
        step(1'b0, 1'b0, 1'b0, 1'b0);
        read_out('0, "R10 chain cleared");

        done = 1;
        summary();
        $finish;
    end

endmodule